// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the word address for each beat of a four-beat burst. A start address is captured whenever either of two active-low strobes is low at a clock edge. From then on only the two lowest address bits move, one step per clock edge on which the active-low step input is low. All higher bits keep the captured value for the whole burst.

The two low bits follow one of two orders, picked by a mode input:

- **Linear (mode low):** the start bits plus a beat count, modulo four.
- **Interleaved (mode high):** the start bits XORed with the beat count.

Boards that leave the mode pin undriven should pull it high, so that it selects interleaved order.

After the fourth beat the sequence returns to the start address and keeps cycling through the same four addresses. A strobe at any point abandons the current burst. A beat index output exposes the count for test and observation.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is active and on the first cycle after it, `acc_addr` is all zeros and `beat_idx` is 0.
- R2: A low level on `strobe_a_n` or on `strobe_b_n` at a rising edge loads `ext_addr`, even during a burst.
  - `acc_addr` equals that address in the following cycle.
  - `beat_idx` equals 0 in the following cycle.
- R3: When a strobe and `step_n` are both low at the same edge, the load wins and `beat_idx` becomes 0.
- R4: With no strobe asserted, bits above bit 1 of `acc_addr` never change.
- R5: With `order_il` = 0 (linear), the low two bits of `acc_addr` are (start + beat_idx) mod 4.
- R6: With `order_il` = 1 (interleaved), the low two bits of `acc_addr` are start XOR beat_idx.
- R7: With no strobe and `step_n` high at an edge, `acc_addr` and `beat_idx` keep their values.
- R8: Each edge with `step_n` low and no strobe advances `beat_idx` by one modulo 4.
  - After four advances, `acc_addr` is back at the start address.
  - Further advances repeat the same four addresses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strobe_a_n | input | 1 | First load strobe, active low |
| strobe_b_n | input | 1 | Second load strobe, active low |
| step_n | input | 1 | Advance to next beat, active low |
| order_il | input | 1 | Order select: 0 linear, 1 interleaved |
| ext_addr | input | ADDR_W | External start address |
| acc_addr | output | ADDR_W | Current access address |
| beat_idx | output | 2 | Current beat count |

## Verification
Every result of this block appears one clock edge after the input that causes it:

- A strobe shows up as the loaded address and a zero beat count in the cycle after the edge that samples it.
- A step shows up as the next sequence address in the cycle after its edge.

The mode select acts combinationally on the stored state. A change of order is therefore visible in the same cycle.

The bench changes inputs 1 ns after a rising edge, then waits for exactly one further edge plus 1 ns before it compares. Each comparison therefore sees the result of exactly one sampled edge.

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe_a_n,
  input  logic              strobe_b_n,
  input  logic              step_n,
  input  logic              order_il,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [1:0]        beat_idx
);
  localparam int HI = ADDR_W - 1;

  logic [ADDR_W-1:0] base_q;
  logic [1:0]        beat_q;
  logic              load;
  logic [1:0]        low_lin, low_il;

  assign load = !strobe_a_n || !strobe_b_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      beat_q <= '0;
    end else if (load) begin
      base_q <= ext_addr;
      beat_q <= '0;
    end else if (!step_n) begin
      beat_q <= beat_q + 2'd1;
    end
  end

  assign low_lin  = base_q[1:0] + beat_q;
  assign low_il   = base_q[1:0] ^ beat_q;
  assign acc_addr = {base_q[HI:2], order_il ? low_il : low_lin};
  assign beat_idx = beat_q;

  // R2
  load_takes_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (acc_addr == $past(ext_addr)));

  // R3
  load_clears_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (beat_idx == 2'd0));

  // R4
  upper_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> (acc_addr[HI:2] == $past(acc_addr[HI:2])));

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && step_n) |=> ($stable(beat_idx) && (!$stable(order_il) || $stable(acc_addr))));

  // R8
  beat_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step_n) |=> (beat_idx == $past(beat_idx) + 2'd1));

  // R5
  linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step_n && !order_il) |=> (order_il || acc_addr[1:0] == $past(acc_addr[1:0]) + 2'd1));
endmodule

// File: tb/burst_addr_seq_tb.sv
`timescale 1ns/1ps
module burst_addr_seq_tb;
  localparam int AW = 17;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          strobe_a_n, strobe_b_n, step_n, order_il;
  logic [AW-1:0] ext_addr;
  logic [AW-1:0] acc_addr;
  logic [1:0]    beat_idx;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .strobe_a_n(strobe_a_n), .strobe_b_n(strobe_b_n),
    .step_n(step_n), .order_il(order_il), .ext_addr(ext_addr),
    .acc_addr(acc_addr), .beat_idx(beat_idx)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [AW-1:0] exp_a, input logic [1:0] exp_b);
    n_cmp++;
    if (acc_addr !== exp_a || beat_idx !== exp_b) begin
      n_bad++;
      $display("FAIL %s: addr=%h beat=%0d expected addr=%h beat=%0d",
               req, acc_addr, beat_idx, exp_a, exp_b);
    end
  endtask

  function automatic logic [AW-1:0] seq_addr(input logic [AW-1:0] s, input logic il, input int k);
    logic [1:0] kb = k[1:0];
    logic [1:0] lo = il ? (s[1:0] ^ kb) : (s[1:0] + kb);
    return {s[AW-1:2], lo};
  endfunction

  task automatic load(input logic [AW-1:0] a, input bit use_b);
    ext_addr = a;
    if (use_b) strobe_b_n = 1'b0; else strobe_a_n = 1'b0;
    tick();
    strobe_a_n = 1'b1;
    strobe_b_n = 1'b1;
    ext_addr = '0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    strobe_a_n = 1'b1; strobe_b_n = 1'b1; step_n = 1'b1; order_il = 1'b0;
    ext_addr = '1;
    tick(); tick();
    chk("R1 in reset", '0, 2'd0);
    rst_n = 1'b1;
    tick();
    chk("R1 after reset", '0, 2'd0);
  endtask

  // R5 R6 R8 R4 R2
  task automatic t_burst(input logic [AW-1:0] a, input logic il, input bit use_b);
    order_il = il;
    load(a, use_b);
    chk("R2 load", a, 2'd0);
    for (int k = 1; k <= 6; k++) begin
      step_n = 1'b0;
      tick();
      chk(il ? "R6 interleaved beat" : "R5 linear beat", seq_addr(a, il, k), 2'(k));
    end
    step_n = 1'b1;
  endtask

  // R7
  task automatic t_hold();
    logic [AW-1:0] a = 17'h0ABC5;
    order_il = 1'b0;
    load(a, 1'b0);
    step_n = 1'b0; tick(); step_n = 1'b1;
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R7 hold", seq_addr(a, 1'b0, 1), 2'd1);
    end
  endtask

  // R2 R3
  task automatic t_interrupt();
    logic [AW-1:0] a = 17'h12342;
    logic [AW-1:0] b = 17'h0F0F3;
    order_il = 1'b1;
    load(a, 1'b0);
    step_n = 1'b0; tick(); tick();
    chk("R6 mid burst", seq_addr(a, 1'b1, 2), 2'd2);
    ext_addr = b; strobe_b_n = 1'b0;
    tick();
    strobe_b_n = 1'b1;
    chk("R3 load beats step", b, 2'd0);
    tick();
    chk("R8 step after reload", seq_addr(b, 1'b1, 1), 2'd1);
    step_n = 1'b1;
    order_il = 1'b0;
    #1;
    chk("R5 mode switch live", seq_addr(b, 1'b0, 1), 2'd1);
  endtask

  initial begin
    t_reset();
    for (int s = 0; s < 4; s++) t_burst(17'h1A5F0 | 17'(s), 1'b0, s[0]);
    for (int s = 0; s < 4; s++) t_burst(17'h05A30 | 17'(s), 1'b1, !s[0]);
    t_hold();
    t_interrupt();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule